// File: doc/BRIEF.md
# Interrupt Controller Mode Register

This block is a 64-bit control register for a local interrupt controller. It holds the controller's base physical address, a flag that marks the bootstrap processor, and two mode bits: a global enable and an extended-mode enable. Software writes the register as one 64-bit word. Before a write is kept, a checker tests it against the rules for moving between modes and against the reserved bits. A legal write is committed. A write that breaks a rule is dropped, and a fault pulse tells the processor to handle it.

The stored mode is decoded into three one-hot outputs: off, legacy and extended. The rest of the controller uses these to pick its behaviour. The whole register can always be read as two 32-bit halves.

The write port is a plain strobe. There is no back-pressure: a strobe is taken on every clock edge at which it is high, and a result is ready for the next strobe one cycle later. The read halves are plain outputs and always show the register's current contents.

Top module: `intc_mode_reg`

## Requirements
- R1: While reset is asserted, and right after it is released, the register holds global enable = 1, extended enable = 0, base field (bits 35:12) = 0xFEE00, and bit 8 = the value of the strap input. With the strap high this reads as rd_lo = 0xFEE00900 and rd_hi = 0. With the strap low it reads as rd_lo = 0xFEE00800.
- R2: Exactly one mode output is high at all times. The mode code is {bit 11, bit 10}: 00 drives mode_off, 10 drives mode_legacy and 11 drives mode_ext.
- R3: In extended mode, a write with bits 11:10 = 10 raises the fault and leaves the register in extended mode, with its contents unchanged.
- R4: In extended mode, the only way out is a write with bits 11:10 = 00, which selects off. A write with 11 is legal and stays in extended mode, and its new base is committed.
- R5: A write with bits 11:10 = 01 always raises the fault and leaves the register unchanged.
- R6: In off mode, a write with bits 11:10 = 11 raises the fault and leaves the register unchanged. Legacy mode has to be entered first.
- R7: A write that sets any reserved bit (bits 7:0, bit 9 or bits 63:36) raises the fault and leaves the register unchanged.
- R8: Bit 8 is read-only. A write never changes it, whatever that write carries in bit 8.
- R9: The fault output is high for exactly the one cycle after a rejected write strobe, and is low after an accepted one.
- R10: rd_lo shows bits 31:0 and rd_hi shows bits 63:32 of the register. Reserved bits read as 0.
- R11: The following writes are accepted, and their value is committed on the clock edge that samples the strobe: from off to 00 or 10, and from legacy to 00, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_bsp | input | 1 | Bootstrap-processor strap, loaded into bit 8 during reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 64 | Value to write |
| rd_lo | output | 32 | Register bits 31:0 |
| rd_hi | output | 32 | Register bits 63:32 |
| mode_off | output | 1 | Controller disabled |
| mode_legacy | output | 1 | Controller enabled, legacy mode |
| mode_ext | output | 1 | Controller enabled, extended mode |
| fault | output | 1 | One-cycle pulse after a rejected write |

## Verification
A chain of writes walks the mode state through legacy, extended and off, and back to legacy. At each step it offers every mode code, so that it separates the pairs of current mode and requested code that are accepted from those that fault. Reserved bits are set one region at a time: low byte, bit 9 and the high word. This shows that each region is checked on its own and not only the bits next to the mode field. Bit 8 is written opposite to the strap, and reset is repeated with the strap at both values, which separates a stored strap from a written bit. After every write, the bench looks at the fault one cycle later and again two cycles later to confirm that it is a single pulse.

// File: rtl/intc_mode_pkg.sv
package intc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_BAD    = 2'b01,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } mode_e;

  localparam int REG_W    = 64;
  localparam int EN_BIT   = 11;
  localparam int EXT_BIT  = 10;
  localparam int BSP_BIT  = 8;
  localparam int BASE_LSB = 12;

  // Bits that software may carry in a write without a fault.
  function automatic logic [REG_W-1:0] usable_mask(input int phys_bits);
    logic [REG_W-1:0] m;
    m = ((REG_W'(1) << phys_bits) - REG_W'(1)) & ~((REG_W'(1) << BASE_LSB) - REG_W'(1));
    m[EN_BIT]  = 1'b1;
    m[EXT_BIT] = 1'b1;
    m[BSP_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/intc_mode_legality.sv
module intc_mode_legality
  import intc_mode_pkg::*;
#(
  parameter int PHYS_ADDR_BITS = 36
) (
  input  mode_e            cur_mode,
  input  logic [REG_W-1:0] wdata,
  output logic             legal
);

  localparam logic [REG_W-1:0] RSV_MASK = ~usable_mask(PHYS_ADDR_BITS);

  mode_e req_mode;
  logic  rsv_hit;
  logic  step_ok;

  assign req_mode = mode_e'({wdata[EN_BIT], wdata[EXT_BIT]});
  assign rsv_hit  = |(wdata & RSV_MASK);

  always_comb begin
    step_ok = 1'b0;
    unique case (cur_mode)
      MODE_OFF:    step_ok = (req_mode == MODE_OFF) || (req_mode == MODE_LEGACY);
      MODE_LEGACY: step_ok = (req_mode != MODE_BAD);
      MODE_EXT:    step_ok = (req_mode == MODE_OFF) || (req_mode == MODE_EXT);
      default:     step_ok = 1'b0;
    endcase
  end

  assign legal = step_ok && !rsv_hit;

endmodule

// File: rtl/intc_mode_state.sv
module intc_mode_state
  import intc_mode_pkg::*;
#(
  parameter int                    BASE_W   = 24,
  parameter logic [BASE_W-1:0]     RST_BASE = BASE_W'(24'hFEE00)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_bsp,
  input  logic              commit,
  input  mode_e             new_mode,
  input  logic [BASE_W-1:0] new_base,
  output mode_e             mode_q,
  output logic [BASE_W-1:0] base_q,
  output logic              bsp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LEGACY;
      base_q <= RST_BASE;
      bsp_q  <= strap_bsp;
    end else if (commit) begin
      mode_q <= new_mode;
      base_q <= new_base;
    end
  end

  // R8: the strap copy never moves once reset is released
  a_r8_bsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(bsp_q));

  // R5: the stored code is never the invalid one
  a_r5_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MODE_BAD);

endmodule

// File: rtl/intc_mode_decode.sv
module intc_mode_decode
  import intc_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_q,
  output logic  is_off,
  output logic  is_legacy,
  output logic  is_ext
);

  always_comb begin
    is_off    = 1'b0;
    is_legacy = 1'b0;
    is_ext    = 1'b0;
    case (mode_q)
      MODE_LEGACY: is_legacy = 1'b1;
      MODE_EXT:    is_ext    = 1'b1;
      default:     is_off    = 1'b1;
    endcase
  end

  // R2: exactly one mode line at a time
  a_r2_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_off, is_legacy, is_ext}) == 1);

endmodule

// File: rtl/intc_mode_reg.sv
module intc_mode_reg
  import intc_mode_pkg::*;
#(
  parameter int PHYS_ADDR_BITS = 36,
  parameter int RST_BASE       = 32'h000FEE00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_bsp,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi,
  output logic        mode_off,
  output logic        mode_legacy,
  output logic        mode_ext,
  output logic        fault
);

  localparam int BASE_W = PHYS_ADDR_BITS - BASE_LSB;
  localparam logic [REG_W-1:0] RSV_MASK = ~usable_mask(PHYS_ADDR_BITS);

  mode_e             mode_q;
  logic [BASE_W-1:0] base_q;
  logic              bsp_q;
  logic              legal;
  logic              commit;
  logic [REG_W-1:0]  value;

  intc_mode_legality #(.PHYS_ADDR_BITS(PHYS_ADDR_BITS)) u_check (
    .cur_mode (mode_q),
    .wdata    (wr_data),
    .legal    (legal)
  );

  assign commit = wr_en && legal;

  intc_mode_state #(
    .BASE_W   (BASE_W),
    .RST_BASE (BASE_W'(RST_BASE))
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_bsp (strap_bsp),
    .commit    (commit),
    .new_mode  (mode_e'({wr_data[EN_BIT], wr_data[EXT_BIT]})),
    .new_base  (wr_data[PHYS_ADDR_BITS-1:BASE_LSB]),
    .mode_q    (mode_q),
    .base_q    (base_q),
    .bsp_q     (bsp_q)
  );

  intc_mode_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .is_off    (mode_off),
    .is_legacy (mode_legacy),
    .is_ext    (mode_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= wr_en && !legal;
  end

  always_comb begin
    value                                 = '0;
    value[PHYS_ADDR_BITS-1:BASE_LSB]      = base_q;
    value[EN_BIT]                         = mode_q[1];
    value[EXT_BIT]                        = mode_q[0];
    value[BSP_BIT]                        = bsp_q;
  end

  assign rd_lo = value[31:0];
  assign rd_hi = value[63:32];

  // R3: leaving extended for legacy is refused
  a_r3_ext_to_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_ext && wr_data[11:10] == 2'b10) |=> (fault && mode_ext));

  // R6: off cannot jump straight to extended
  a_r6_off_to_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_off && wr_data[11:10] == 2'b11) |=> (fault && mode_off));

  // R5: invalid code leaves contents alone
  a_r5_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[11:10] == 2'b01) |=> (fault && $stable({rd_hi, rd_lo})));

  // R7: reserved bits leave contents alone
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_data & RSV_MASK)) |=> (fault && $stable({rd_hi, rd_lo})));

  // R9: every fault pulse follows a strobe
  a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(wr_en));

  // R4: extended mode only ever exits to off
  a_r4_ext_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_ext) && !mode_ext) |-> mode_off);

endmodule

// File: tb/intc_mode_reg_tb_top.sv
`timescale 1ns/1ps
module intc_mode_reg_tb_top;

  typedef struct packed {
    logic [63:0] wd;
    logic        flt;
    logic [1:0]  md;
    logic [23:0] base;
  } vec_t;

  function automatic logic [63:0] mk(input logic [1:0] md, input logic [23:0] b,
                                     input logic [63:0] extra);
    return ({40'd0, b} << 12) | (64'(md) << 10) | extra;
  endfunction

  // Walk from reset (legacy, base FEE00, strap = 1)
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{mk(2'b10, 24'h012345, 64'h0), 1'b0, 2'b10, 24'h012345}, // R11 legacy->legacy
    '{mk(2'b11, 24'h012345, 64'h0), 1'b0, 2'b11, 24'h012345}, // R11 legacy->ext
    '{mk(2'b10, 24'h022222, 64'h0), 1'b1, 2'b11, 24'h012345}, // R3 ext->legacy refused
    '{mk(2'b11, 24'h054321, 64'h0), 1'b0, 2'b11, 24'h054321}, // R4 ext->ext new base
    '{mk(2'b01, 24'h000000, 64'h0), 1'b1, 2'b11, 24'h054321}, // R5 invalid code
    '{mk(2'b11, 24'h054321, 64'h1 << 40), 1'b1, 2'b11, 24'h054321}, // R7 high word
    '{mk(2'b00, 24'h000000, 64'h0), 1'b0, 2'b00, 24'h000000}, // R4 ext->off
    '{mk(2'b11, 24'h0ABCDE, 64'h0), 1'b1, 2'b00, 24'h000000}, // R6 off->ext refused
    '{mk(2'b01, 24'h0ABCDE, 64'h0), 1'b1, 2'b00, 24'h000000}, // R5 invalid from off
    '{mk(2'b10, 24'h0ABCDE, 64'h0), 1'b0, 2'b10, 24'h0ABCDE}, // R11 off->legacy, R8 bit8=0
    '{mk(2'b10, 24'h011111, 64'h8), 1'b1, 2'b10, 24'h0ABCDE}, // R7 low byte
    '{mk(2'b10, 24'h011111, 64'h200), 1'b1, 2'b10, 24'h0ABCDE}, // R7 bit 9
    '{mk(2'b00, 24'h000000, 64'h0), 1'b0, 2'b00, 24'h000000}, // R11 legacy->off
    '{mk(2'b00, 24'h000000, 64'h0), 1'b0, 2'b00, 24'h000000}, // R11 off->off
    '{mk(2'b10, 24'h0FEE00, 64'h0), 1'b0, 2'b10, 24'h0FEE00}  // R11 off->legacy
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_bsp = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [31:0] rd_lo, rd_hi;
  logic        mode_off, mode_legacy, mode_ext, fault;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  intc_mode_reg dut_i (
    .clk(clk), .rst_n(rst_n), .strap_bsp(strap_bsp), .wr_en(wr_en), .wr_data(wr_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .mode_off(mode_off), .mode_legacy(mode_legacy),
    .mode_ext(mode_ext), .fault(fault)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [1:0] md,
                             input logic [23:0] b, input logic bsp);
    logic [63:0] exp;
    exp = ({40'd0, b} << 12) | (64'(md) << 10) | (64'(bsp) << 8);
    check({tag, " rd_lo (R10)"}, 64'(rd_lo), 64'(exp[31:0]));
    check({tag, " rd_hi (R10)"}, 64'(rd_hi), 64'(exp[63:32]));
    check({tag, " modes (R2)"}, 64'({mode_off, mode_legacy, mode_ext}),
          64'({md == 2'b00, md == 2'b10, md == 2'b11}));
  endtask

  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap_bsp = s;
    rst_n     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state with strap high
    do_reset(1'b1);
    check("R1 reset rd_lo strap=1", 64'(rd_lo), 64'hFEE00900);
    check("R1 reset rd_hi", 64'(rd_hi), 64'h0);
    check("R1 reset fault low", 64'(fault), 64'h0);
    check_state("R1 reset", 2'b10, 24'h0FEE00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].wd);
      check($sformatf("R9 vec%0d fault pulse", i), 64'(fault), 64'(VECS[i].flt));
      check_state($sformatf("vec%0d", i), VECS[i].md, VECS[i].base, 1'b1);
      @(negedge clk);
      check($sformatf("R9 vec%0d fault gone", i), 64'(fault), 64'h0);
    end

    // R8: writing bit 8 = 1 with strap low leaves it 0
    do_reset(1'b0);
    check("R1 reset rd_lo strap=0", 64'(rd_lo), 64'hFEE00800);
    do_write(mk(2'b10, 24'h033333, 64'h100));
    check("R8 bit8 ignored fault", 64'(fault), 64'h0);
    check_state("R8 bit8 ignored", 2'b10, 24'h033333, 1'b0);

    // R9: back-to-back rejected strobes give back-to-back pulses
    @(negedge clk);
    wr_en = 1'b1; wr_data = mk(2'b01, 24'h0, 64'h0);
    @(negedge clk);
    check("R9 first of pair", 64'(fault), 64'h1);
    wr_data = mk(2'b10, 24'h0, 64'h1);
    @(negedge clk);
    check("R9 second of pair", 64'(fault), 64'h1);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    check("R9 pair ends", 64'(fault), 64'h0);
    check_state("R7 after pair", 2'b10, 24'h033333, 1'b0);

    // R6: off->legacy->ext is the permitted route
    do_write(mk(2'b00, 24'h0, 64'h0));
    do_write(mk(2'b10, 24'h044444, 64'h0));
    do_write(mk(2'b11, 24'h044444, 64'h0));
    check("R6 via legacy fault", 64'(fault), 64'h0);
    check_state("R6 via legacy", 2'b11, 24'h044444, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule